// File: doc/BRIEF.md
# Peek/Poke Command Packet Processor

This block executes register-access requests that arrive as a stream of 32-bit words. Each request is a fixed-size packet. The block first checks the packet's identifier. It then decodes the command held in the flags word and runs it against a simple register bus: an echo, a single write, a single read, a block of writes or a block of reads. When the request asks for an acknowledgement, the block sends back a response packet of the same size.

Every packet holds exactly `5 + MAX_WORDS` words, in this order: identifier, flags, sequence, word count, address, then `MAX_WORDS` data words. With the defaults that is 21 words.

The low 16 bits of the identifier word carry three fields:

| Bits | Field |
|------|-------|
| [15:8] | Signature |
| [7:4] | Protocol version |
| [3:0] | Product number |

The flags word carries the following fields:

| Bits | Field |
|------|-------|
| [3:0] | Command |
| [8] | Acknowledge request |
| [23:16] | Error field |
| [16] | Unknown-command error (inside the error field) |
| [17] | Size error (inside the error field) |

The command codes are: echo = 0, single write = 1, single read = 2, block write = 3, block read = 4.

The response is the request with these changes: the error field is rewritten, the word count is clamped, and read results are placed into the data words. The block accepts input only while idle. Register accesses go out one per cycle with a ready/valid handshake, and the response follows once the last access has completed.

Top module: `pp_cmd_proc`

## Requirements
- R1: A packet is executed only if identifier bits [15:8] equal `SIGNATURE`, bits [7:4] are less than or equal to `PROTO_VER`, and bits [3:0] equal `PRODUCT_ID`. Any other packet is consumed in full but causes no bus access and no response.
- R2: Response words 0 (identifier), 2 (sequence) and 4 (address) equal the request's words. Response word 1 equals the request flags with bits [23:16] cleared, before any error bit is set. Data words that no read overwrites are returned unchanged.
- R3: Command 0 (echo) makes no bus access.
- R4: Command 1 performs one bus write (`bus_we_o`=1) to the request address, with data word 0 as write data.
- R5: Command 2 performs one bus read of the request address. Response data word 0 then holds the read data.
- R6: Commands 3 and 4 perform N writes or N reads, where N is the word count. The access with index i targets address + 4·i, and the accesses go out in increasing order of i. Block writes use data word i; block reads return their results in data word i. A count of 0 makes no access.
- R7: For commands 3 and 4, a word count above `MAX_WORDS` sets flags bit 17 and clamps both N and response word 3 to `MAX_WORDS`. For all other commands, word 3 is returned unchanged and bit 17 stays clear.
- R8: A command code above 4 sets flags bit 16 and makes no bus access.
- R9: A response is emitted only if request flags bit 8 is set. The bus accesses are performed either way.
- R10: A response is `5 + MAX_WORDS` consecutive valid words. `out_last_o` is high only on the final word. `in_ready_o` is low from the cycle after a packet's last word until processing ends.
- R11: After reset, `in_ready_o` is high and `bus_req_o` and `out_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request word valid |
| in_data_i | input | 32 | Request word |
| in_ready_o | output | 1 | Block accepts a request word |
| bus_req_o | output | 1 | Register access pending |
| bus_we_o | output | 1 | Access is a write |
| bus_addr_o | output | 32 | Access byte address |
| bus_wdata_o | output | 32 | Write data |
| bus_ready_i | input | 1 | Access completes this cycle |
| bus_rdata_i | input | 32 | Read data, valid with bus_ready_i |
| out_valid_o | output | 1 | Response word valid |
| out_data_o | output | 32 | Response word |
| out_last_o | output | 1 | Final response word |

## Verification
Each fault has a visible symptom at the ports:

- **Word-count fault.** If the receive word counter slips, header fields land in the data buffer. The next bus address or response header is then wrong within one packet.
- **Access-index fault.** A wrong access index shows as a skipped or repeated address step on the bus during the same block.
- **Decode or clamp fault.** A bad decision here changes the number of bus accesses. It also changes bits 16 and 17 or word 3 of the response, which appear a few cycles after the last access.
- **Acceptance or acknowledge fault.** A bad decision here produces bus activity or response words where none are expected. Because the bench compares every cycle against its model, the first unexpected cycle is flagged.

// File: rtl/pp_pkg.sv
package pp_pkg;
  localparam int WORD_W    = 32;
  localparam int HDR_WORDS = 5;

  localparam int ID_SIG_LSB  = 8;
  localparam int ID_VER_LSB  = 4;
  localparam int ID_PROD_LSB = 0;

  localparam int FLG_ACK      = 8;
  localparam int FLG_ERR_CMD  = 16;
  localparam int FLG_ERR_SIZE = 17;
  localparam logic [WORD_W-1:0] FLG_ERR_MASK = 32'h00FF_0000;

  typedef enum logic [3:0] {
    CMD_ECHO  = 4'd0,
    CMD_POKE  = 4'd1,
    CMD_PEEK  = 4'd2,
    CMD_BPOKE = 4'd3,
    CMD_BPEEK = 4'd4
  } pp_cmd_e;

  typedef struct packed {
    logic [WORD_W-1:0] id;
    logic [WORD_W-1:0] flags;
    logic [WORD_W-1:0] seq;
    logic [WORD_W-1:0] count;
    logic [WORD_W-1:0] addr;
  } pp_hdr_t;
endpackage

// File: rtl/pp_rx.sv
module pp_rx
  import pp_pkg::*;
#(
  parameter int MAX_WORDS = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         in_valid_i,
  input  logic [WORD_W-1:0]            in_data_i,
  output pp_hdr_t                      hdr_o,
  output logic                         wr_en_o,
  output logic [$clog2(MAX_WORDS)-1:0] wr_idx_o,
  output logic [WORD_W-1:0]            wr_data_o,
  output logic                         last_o
);
  localparam int PKT_WORDS = HDR_WORDS + MAX_WORDS;
  localparam int CNT_W     = $clog2(PKT_WORDS);
  localparam int IDX_W     = $clog2(MAX_WORDS);

  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] hw_q [HDR_WORDS];
  logic              take;

  assign take      = en_i & in_valid_i;
  assign last_o    = take && (cnt_q == CNT_W'(PKT_WORDS - 1));
  assign wr_en_o   = take && (cnt_q >= CNT_W'(HDR_WORDS));
  assign wr_idx_o  = IDX_W'(cnt_q - CNT_W'(HDR_WORDS));
  assign wr_data_o = in_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < HDR_WORDS; i++) hw_q[i] <= '0;
    end else if (take) begin
      cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      if (cnt_q < CNT_W'(HDR_WORDS)) hw_q[cnt_q[2:0]] <= in_data_i;
    end
  end

  assign hdr_o = '{id: hw_q[0], flags: hw_q[1], seq: hw_q[2], count: hw_q[3], addr: hw_q[4]};
endmodule

// File: rtl/pp_exec.sv
module pp_exec
  import pp_pkg::*;
#(
  parameter int MAX_WORDS = 16
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           start_i,
  input  logic                           write_i,
  input  logic [WORD_W-1:0]              base_i,
  input  logic [$clog2(MAX_WORDS+1)-1:0] num_i,
  output logic                           done_o,
  output logic                           bus_req_o,
  output logic                           bus_we_o,
  output logic [WORD_W-1:0]              bus_addr_o,
  output logic [WORD_W-1:0]              bus_wdata_o,
  input  logic                           bus_ready_i,
  input  logic [WORD_W-1:0]              bus_rdata_i,
  output logic [$clog2(MAX_WORDS)-1:0]   rd_idx_o,
  input  logic [WORD_W-1:0]              rd_data_i,
  output logic                           wr_en_o,
  output logic [$clog2(MAX_WORDS)-1:0]   wr_idx_o,
  output logic [WORD_W-1:0]              wr_data_o
);
  localparam int NUM_W = $clog2(MAX_WORDS + 1);
  localparam int IDX_W = $clog2(MAX_WORDS);

  logic              busy_q, we_q;
  logic [WORD_W-1:0] base_q;
  logic [NUM_W-1:0]  num_q, idx_q;
  logic              fire;

  assign bus_req_o   = busy_q && (idx_q != num_q);
  assign done_o      = busy_q && (idx_q == num_q);
  assign fire        = bus_req_o && bus_ready_i;
  assign bus_we_o    = we_q;
  assign bus_addr_o  = base_q + {{(WORD_W-NUM_W-2){1'b0}}, idx_q, 2'b00};
  assign rd_idx_o    = IDX_W'(idx_q);
  assign bus_wdata_o = rd_data_i;
  assign wr_en_o     = fire && !we_q;
  assign wr_idx_o    = IDX_W'(idx_q);
  assign wr_data_o   = bus_rdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      we_q   <= 1'b0;
      base_q <= '0;
      num_q  <= '0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      we_q   <= write_i;
      base_q <= base_i;
      num_q  <= num_i;
      idx_q  <= '0;
    end else if (done_o) begin
      busy_q <= 1'b0;
    end else if (fire) begin
      idx_q <= idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/pp_tx.sv
module pp_tx
  import pp_pkg::*;
#(
  parameter int MAX_WORDS = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  pp_hdr_t                      hdr_i,
  output logic [$clog2(MAX_WORDS)-1:0] rd_idx_o,
  input  logic [WORD_W-1:0]            rd_data_i,
  output logic                         out_valid_o,
  output logic [WORD_W-1:0]            out_data_o,
  output logic                         out_last_o
);
  localparam int PKT_WORDS = HDR_WORDS + MAX_WORDS;
  localparam int CNT_W     = $clog2(PKT_WORDS);
  localparam int IDX_W     = $clog2(MAX_WORDS);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] hw [HDR_WORDS];

  assign hw[0] = hdr_i.id;
  assign hw[1] = hdr_i.flags;
  assign hw[2] = hdr_i.seq;
  assign hw[3] = hdr_i.count;
  assign hw[4] = hdr_i.addr;

  assign out_valid_o = busy_q;
  assign out_last_o  = busy_q && (cnt_q == CNT_W'(PKT_WORDS - 1));
  assign rd_idx_o    = IDX_W'(cnt_q - CNT_W'(HDR_WORDS));
  assign out_data_o  = (cnt_q < CNT_W'(HDR_WORDS)) ? hw[cnt_q[2:0]] : rd_data_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      busy_q <= !out_last_o;
      cnt_q  <= out_last_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pp_cmd_proc.sv
module pp_cmd_proc
  import pp_pkg::*;
#(
  parameter int         MAX_WORDS  = 16,
  parameter logic [7:0] SIGNATURE  = 8'hA5,
  parameter logic [3:0] PROTO_VER  = 4'd2,
  parameter logic [3:0] PRODUCT_ID = 4'd7
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        in_valid_i,
  input  logic [31:0] in_data_i,
  output logic        in_ready_o,
  output logic        bus_req_o,
  output logic        bus_we_o,
  output logic [31:0] bus_addr_o,
  output logic [31:0] bus_wdata_o,
  input  logic        bus_ready_i,
  input  logic [31:0] bus_rdata_i,
  output logic        out_valid_o,
  output logic [31:0] out_data_o,
  output logic        out_last_o
);
  localparam int IDX_W = $clog2(MAX_WORDS);
  localparam int NUM_W = $clog2(MAX_WORDS + 1);

  typedef enum logic [1:0] {S_RX, S_CHK, S_EXEC, S_TX} state_e;
  state_e state_q;

  pp_hdr_t           rx_hdr, tx_hdr;
  logic              rx_wr_en, rx_last, ex_wr_en, ex_done, ex_start, tx_start;
  logic [IDX_W-1:0]  rx_wr_idx, ex_wr_idx, ex_rd_idx, tx_rd_idx, rd_idx;
  logic [WORD_W-1:0] rx_wr_data, ex_wr_data, rd_data;
  logic [WORD_W-1:0] buf_q [MAX_WORDS];

  // decode of the held request
  logic              id_ok, is_block, over, known, is_write, ack;
  logic [3:0]        cmd;
  logic [NUM_W-1:0]  num;
  logic [WORD_W-1:0] rsp_flags, rsp_count, rsp_flags_q, rsp_count_q;

  always_comb begin
    id_ok    = (rx_hdr.id[ID_SIG_LSB +: 8] == SIGNATURE) &&
               (rx_hdr.id[ID_VER_LSB +: 4] <= PROTO_VER) &&
               (rx_hdr.id[ID_PROD_LSB +: 4] == PRODUCT_ID);
    cmd      = rx_hdr.flags[3:0];
    ack      = rx_hdr.flags[FLG_ACK];
    is_block = (cmd == CMD_BPOKE) || (cmd == CMD_BPEEK);
    known    = (cmd <= CMD_BPEEK);
    is_write = (cmd == CMD_POKE) || (cmd == CMD_BPOKE);
    over     = rx_hdr.count > WORD_W'(MAX_WORDS);
    if (is_block) num = over ? NUM_W'(MAX_WORDS) : NUM_W'(rx_hdr.count);
    else if ((cmd == CMD_POKE) || (cmd == CMD_PEEK)) num = NUM_W'(1);
    else num = '0;
    rsp_flags = rx_hdr.flags & ~FLG_ERR_MASK;
    if (!known) rsp_flags[FLG_ERR_CMD] = 1'b1;
    if (is_block && over) rsp_flags[FLG_ERR_SIZE] = 1'b1;
    rsp_count = (is_block && over) ? WORD_W'(MAX_WORDS) : rx_hdr.count;
  end

  assign in_ready_o = (state_q == S_RX);
  assign ex_start   = (state_q == S_CHK) && id_ok;
  assign tx_start   = (state_q == S_EXEC) && ex_done && ack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_RX;
      rsp_flags_q <= '0;
      rsp_count_q <= '0;
    end else begin
      case (state_q)
        S_RX:   if (rx_last) state_q <= S_CHK;
        S_CHK: begin
          rsp_flags_q <= rsp_flags;
          rsp_count_q <= rsp_count;
          state_q     <= id_ok ? S_EXEC : S_RX;
        end
        S_EXEC: if (ex_done) state_q <= ack ? S_TX : S_RX;
        S_TX:   if (out_last_o) state_q <= S_RX;
        default: state_q <= S_RX;
      endcase
    end
  end

  // shared request/response data store
  always_ff @(posedge clk_i) begin
    if (rx_wr_en) buf_q[rx_wr_idx] <= rx_wr_data;
    else if (ex_wr_en) buf_q[ex_wr_idx] <= ex_wr_data;
  end

  assign rd_idx  = (state_q == S_TX) ? tx_rd_idx : ex_rd_idx;
  assign rd_data = buf_q[rd_idx];
  assign tx_hdr  = '{id: rx_hdr.id, flags: rsp_flags_q, seq: rx_hdr.seq,
                     count: rsp_count_q, addr: rx_hdr.addr};

  pp_rx #(.MAX_WORDS(MAX_WORDS)) u_rx (
    .clk_i, .rst_ni,
    .en_i      (in_ready_o),
    .in_valid_i,
    .in_data_i,
    .hdr_o     (rx_hdr),
    .wr_en_o   (rx_wr_en),
    .wr_idx_o  (rx_wr_idx),
    .wr_data_o (rx_wr_data),
    .last_o    (rx_last)
  );

  pp_exec #(.MAX_WORDS(MAX_WORDS)) u_exec (
    .clk_i, .rst_ni,
    .start_i    (ex_start),
    .write_i    (is_write),
    .base_i     (rx_hdr.addr),
    .num_i      (num),
    .done_o     (ex_done),
    .bus_req_o,
    .bus_we_o,
    .bus_addr_o,
    .bus_wdata_o,
    .bus_ready_i,
    .bus_rdata_i,
    .rd_idx_o   (ex_rd_idx),
    .rd_data_i  (rd_data),
    .wr_en_o    (ex_wr_en),
    .wr_idx_o   (ex_wr_idx),
    .wr_data_o  (ex_wr_data)
  );

  pp_tx #(.MAX_WORDS(MAX_WORDS)) u_tx (
    .clk_i, .rst_ni,
    .start_i    (tx_start),
    .hdr_i      (tx_hdr),
    .rd_idx_o   (tx_rd_idx),
    .rd_data_i  (rd_data),
    .out_valid_o,
    .out_data_o,
    .out_last_o
  );
endmodule

// File: rtl/pp_cmd_proc_chk.sv
module pp_cmd_proc_chk #(
  parameter int MAX_WORDS = 16
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        in_ready_o,
  input logic        bus_req_o,
  input logic        bus_we_o,
  input logic [31:0] bus_addr_o,
  input logic        bus_ready_i,
  input logic        out_valid_o,
  input logic        out_last_o
);
  localparam int PKT_WORDS = 5 + MAX_WORDS;
  localparam int CNT_W     = $clog2(PKT_WORDS);

  logic [CNT_W-1:0] ocnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ocnt_q <= '0;
    else if (out_valid_o) ocnt_q <= out_last_o ? '0 : ocnt_q + 1'b1;
  end

  AST_BUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_req_o && !bus_ready_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o))) // R6
    else $error("bus request dropped or changed while stalled");

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bus_req_o && bus_ready_i) && bus_req_o) |-> (bus_addr_o == $past(bus_addr_o) + 32'd4)) // R6
    else $error("block address did not step by 4");

  AST_BUS_NOT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !in_ready_o) // R10
    else $error("input accepted during bus phase");

  AST_OUT_NOT_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (!in_ready_o && !bus_req_o)) // R10
    else $error("response overlaps input or bus phase");

  AST_LAST_POS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_last_o == (ocnt_q == CNT_W'(PKT_WORDS - 1)))) // R10
    else $error("last marker misplaced");

  AST_LAST_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_last_o |-> out_valid_o) // R10
    else $error("last without valid");
endmodule

bind pp_cmd_proc pp_cmd_proc_chk #(.MAX_WORDS(MAX_WORDS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_ready_o  (in_ready_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_ready_i (bus_ready_i),
  .out_valid_o (out_valid_o),
  .out_last_o  (out_last_o)
);

// File: tb/tb_pp_cmd_proc.sv
`timescale 1ns/1ps
module tb_pp_cmd_proc;
  localparam int MAXW = 16;
  localparam int PKT  = 5 + MAXW;
  localparam logic [7:0] SIG  = 8'hA5;
  localparam logic [3:0] VER  = 4'd2;
  localparam logic [3:0] PROD = 4'd7;

  typedef logic [31:0] pkt_t [PKT];

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic        in_ready_o;
  logic        bus_req_o, bus_we_o;
  logic [31:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
  logic        bus_ready_i = 1'b0;
  logic        out_valid_o, out_last_o;
  logic [31:0] out_data_o;

  int unsigned n_vec = 0, n_err = 0, ocnt = 0, cyc = 0;
  bit done = 1'b0;

  logic [31:0] q_out [$];
  string       q_otag [$];
  logic        q_we [$];
  logic [31:0] q_addr [$], q_wd [$];
  string       q_btag [$];

  always #2 clk = ~clk;

  pp_cmd_proc #(.MAX_WORDS(MAXW), .SIGNATURE(SIG), .PROTO_VER(VER), .PRODUCT_ID(PROD)) dut (
    .clk_i(clk), .rst_ni, .in_valid_i, .in_data_i, .in_ready_o,
    .bus_req_o, .bus_we_o, .bus_addr_o, .bus_wdata_o, .bus_ready_i, .bus_rdata_i,
    .out_valid_o, .out_data_o, .out_last_o);

  function automatic logic [31:0] rd_val(logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  assign bus_rdata_i = rd_val(bus_addr_o);

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus ready pattern with periodic stalls
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    bus_ready_i = (cyc % 3) != 2;
  end

  // per-cycle comparison against model queues
  always @(negedge clk) if (rst_ni && !done) begin
    if (bus_req_o && bus_ready_i) begin
      if (q_we.size() == 0) check(1'b0, "R1 R3 R8 unexpected bus access", bus_addr_o, 32'h0);
      else begin
        logic we_e; logic [31:0] a_e, w_e; string t;
        we_e = q_we.pop_front(); a_e = q_addr.pop_front(); w_e = q_wd.pop_front(); t = q_btag.pop_front();
        check(bus_we_o == we_e, {t, " bus direction"}, 32'(bus_we_o), 32'(we_e));
        check(bus_addr_o == a_e, {t, " bus address"}, bus_addr_o, a_e);
        if (we_e) check(bus_wdata_o == w_e, {t, " bus write data"}, bus_wdata_o, w_e);
      end
    end
    if (out_valid_o) begin
      if (q_out.size() == 0) check(1'b0, "R1 R9 unexpected response word", out_data_o, 32'h0);
      else begin
        logic [31:0] e; string t;
        e = q_out.pop_front(); t = q_otag.pop_front();
        check(out_data_o == e, {t, " response word"}, out_data_o, e);
      end
      check(out_last_o == (ocnt == PKT - 1), "R10 last marker", 32'(out_last_o), 32'(ocnt == PKT - 1));
      ocnt = (ocnt == PKT - 1) ? 0 : ocnt + 1;
    end
  end

  task automatic push_bus(logic we, logic [31:0] a, logic [31:0] wd, string t);
    q_we.push_back(we); q_addr.push_back(a); q_wd.push_back(wd); q_btag.push_back(t);
  endtask

  task automatic model(pkt_t p);
    logic [31:0] fl, cnt, d [MAXW];
    int n;
    string dtag, ftag, ctag;
    if (!(p[0][15:8] == SIG && p[0][7:4] <= VER && p[0][3:0] == PROD)) return;
    fl = p[1] & ~32'h00FF_0000; cnt = p[3];
    for (int i = 0; i < MAXW; i++) d[i] = p[5+i];
    dtag = "R2"; ftag = "R2"; ctag = "R2";
    case (p[1][3:0])
      4'd0: ;
      4'd1: push_bus(1'b1, p[4], d[0], "R4");
      4'd2: begin push_bus(1'b0, p[4], 32'h0, "R5"); d[0] = rd_val(p[4]); dtag = "R5"; end
      4'd3, 4'd4: begin
        n = (p[3] > MAXW) ? MAXW : int'(p[3]);
        ctag = "R7";
        if (p[3] > MAXW) begin fl[17] = 1'b1; cnt = MAXW; ftag = "R7"; end
        for (int i = 0; i < n; i++) begin
          if (p[1][3:0] == 4'd3) push_bus(1'b1, p[4] + 32'(4*i), d[i], "R6");
          else begin push_bus(1'b0, p[4] + 32'(4*i), 32'h0, "R6"); d[i] = rd_val(p[4] + 32'(4*i)); end
        end
        if (p[1][3:0] == 4'd4) dtag = "R6";
      end
      default: begin fl[16] = 1'b1; ftag = "R8"; end
    endcase
    if (!p[1][8]) return;
    q_out.push_back(p[0]); q_otag.push_back("R2");
    q_out.push_back(fl);   q_otag.push_back(ftag);
    q_out.push_back(p[2]); q_otag.push_back("R2");
    q_out.push_back(cnt);  q_otag.push_back(ctag);
    q_out.push_back(p[4]); q_otag.push_back("R2");
    for (int i = 0; i < MAXW; i++) begin q_out.push_back(d[i]); q_otag.push_back(dtag); end
  endtask

  task automatic send(logic [15:0] idl, logic [31:0] fl, logic [31:0] cnt, logic [31:0] addr, logic [31:0] seed);
    pkt_t p;
    bit ok;
    p[0] = {16'hBEEF, idl}; p[1] = fl; p[2] = seed ^ 32'h0F0F_0000; p[3] = cnt; p[4] = addr;
    for (int i = 0; i < MAXW; i++) p[5+i] = seed + 32'(i) * 32'h0101_0101;
    model(p);
    for (int k = 0; k < PKT; k++) begin
      in_valid_i = 1'b1; in_data_i = p[k];
      do begin
        @(negedge clk); ok = in_ready_o;
        @(posedge clk); #1;
      end while (!ok);
    end
    in_valid_i = 1'b0;
    @(negedge clk);
    check(in_ready_o == 1'b0, "R10 ready low after last word", 32'(in_ready_o), 32'h0);
  endtask

  localparam logic [15:0] GOOD = {SIG, VER, PROD};
  localparam logic [31:0] ACK  = 32'h100;

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_ni = 1'b1;
    @(negedge clk);
    check(in_ready_o == 1'b1, "R11 ready after reset", 32'(in_ready_o), 32'h1);
    check(bus_req_o == 1'b0, "R11 no bus request after reset", 32'(bus_req_o), 32'h0);
    check(out_valid_o == 1'b0, "R11 no response after reset", 32'(out_valid_o), 32'h0);
    @(posedge clk); #1;

    send(GOOD, ACK | 32'd1, 32'd1, 32'h0000_1000, 32'hA000_0001);          // R4 single write
    send(GOOD, ACK | 32'd2, 32'd1, 32'h0000_2004, 32'hB000_0002);          // R5 single read
    send(GOOD, ACK | 32'd3, 32'd5, 32'h0000_3000, 32'hC000_0003);          // R6 block write
    send(GOOD, ACK | 32'd4, 32'd16, 32'h0000_4000, 32'hD000_0004);         // R6 block read at max
    send(GOOD, ACK | 32'd4, 32'd20, 32'h0000_5000, 32'hE000_0005);         // R7 clamp read
    send(GOOD, ACK | 32'd3, 32'd17, 32'h0000_5800, 32'hE100_0015);         // R7 clamp write
    send(GOOD, ACK | 32'd3, 32'd0, 32'h0000_6000, 32'hF000_0006);          // R6 zero count
    send(GOOD, ACK | 32'h00AB_0000, 32'd40, 32'h0000_7000, 32'h1000_0007); // R3 R2 echo, errors cleared, count kept
    send(GOOD, ACK | 32'd9, 32'd2, 32'h0000_8000, 32'h2000_0008);          // R8 unknown command
    send(GOOD, 32'd1, 32'd1, 32'h0000_9000, 32'h3000_0009);                // R9 write without ack
    send(GOOD, 32'd4, 32'd3, 32'h0000_9100, 32'h3100_0019);                // R9 block read without ack
    send({8'h5A, VER, PROD}, ACK | 32'd1, 32'd1, 32'h0000_A000, 32'h4000_000A); // R1 bad signature
    send({SIG, VER + 4'd1, PROD}, ACK | 32'd1, 32'd1, 32'h0000_B000, 32'h5000_000B); // R1 newer version
    send({SIG, PROD ^ 4'd1, PROD}, ACK | 32'd2, 32'd1, 32'h0, 32'h0) ;     // R1 version field 6 > 2
    send({SIG, VER, PROD + 4'd1}, ACK | 32'd2, 32'd1, 32'h0000_C000, 32'h6000_000C); // R1 wrong product
    send({SIG, 4'd0, PROD}, ACK | 32'd2, 32'd1, 32'h0000_D000, 32'h7000_000D); // R1 older version
    send(GOOD, ACK | 32'd1, 32'd1, 32'h0000_E000, 32'h8000_000E);          // R1 accepted after drops

    for (int w = 0; w < 3000 && (q_out.size() != 0 || q_we.size() != 0); w++) @(posedge clk);
    repeat (40) @(posedge clk);
    @(negedge clk);
    check(q_out.size() == 0, "R9 all expected response words seen", 32'(q_out.size()), 32'h0);
    check(q_we.size() == 0, "R6 all expected bus accesses seen", 32'(q_we.size()), 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_vec++; n_err++;
      $display("FAIL R10 watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  end
endmodule